// File: doc/BRIEF.md
# CPU clock select and standby controller

This block derives the CPU clock of a small microcontroller from two sources: a fast main oscillator and a slow subsystem oscillator. The main source passes through a binary divider chain. Software picks one of five divided main rates through a mode register, or picks the subsystem clock through a standby control register. Any change of source or rate goes through a glitch-free switch. The switch moves only when both the old clock and the new clock are low. A status output shows which source is currently active.

The same standby control register starts the HALT and STOP standby modes. HALT holds the CPU clock low. STOP also turns off the main oscillator. An unmasked interrupt or a reset ends either mode. The set of standby modes that software may use depends on the active source. While the subsystem clock is selected, a STOP request has no effect. The main oscillator may be stopped only after the CPU already runs from the subsystem clock. The subsystem oscillator may be shut down only while it is not needed as the CPU source.

The block drives both oscillator enables, the gated CPU clock, a peripheral clock derived from the main source, and an always-on copy of the subsystem clock for the 16-bit timer, the watch timer and the clock output function. The design is fully synchronous to `clk`, the main oscillator domain. The subsystem oscillator arrives as a slow level on `sub_clk_in`. The main divider runs only while the main oscillator enable is high.

Top module: `clkgen_top`

## Requirements
- R1: After reset the standby control register holds 04H and the mode register holds 00H. The CPU clock period is then 32 `clk` cycles, `cpu_src_sub` is 0, and the peripheral clock runs.
- R2: While `rst` is high, `main_osc_en` is 0. It returns to 1 once reset is released.
- R3: A write of code c to mode register bits [2:0] (`wr_addr`=1) sets the main CPU clock period to 2^(5-c) `clk` cycles for c = 0..4. Codes 5, 6 and 7 give a period of 2.
- R4: Standby register bit 5 (`wr_addr`=0) selects the subsystem clock as the CPU clock. Once the switch has completed, `cpu_src_sub` is 1 and the CPU clock period equals the period of `sub_clk_in`. Clearing bit 5 returns the CPU clock to the selected main rate. A switch happens only while both the old clock and the new clock are low, so no shortened pulse appears on `cpu_clk`.
- R5: A standby write with bits [1:0] = 01 enters HALT. `cpu_clk` is then held low. `main_osc_en` stays 1 and the peripheral and subsystem outputs keep running.
- R6: A standby write with bits [1:0] = 10 while the main clock is selected and active enters STOP. `cpu_clk`, `main_osc_en` and `peri_clk` are then all 0.
- R7: A high `irq_pending` or a reset ends HALT or STOP, and the CPU clock resumes at the configured rate.
- R8: A STOP request is ignored while the subsystem clock is selected or active. The CPU clock keeps running and `main_osc_en` stays 1.
- R9: Standby bit 6 stops the main oscillator. The write is accepted only while the subsystem clock is both selected and active. The main oscillator then stops: `main_osc_en` and `peri_clk` are 0, and the CPU keeps running on the subsystem clock. At any other time bit 6 is ignored. While the main oscillator is stopped, a write that clears bit 5 but keeps bit 6 set does not move the CPU off the subsystem clock.
- R10: Standby bit 7 shuts down the subsystem oscillator: `sub_osc_en` and `sub_clk_out` are 0. The bit is ignored while the subsystem clock is selected, requested or active.
- R11: While the subsystem oscillator is enabled, `sub_clk_out` follows `sub_clk_in` in every mode, including HALT, STOP and main stop.
- R12: While standby bit 2 is 1 and the main oscillator runs, `peri_clk` is the main clock divided by 2. When bit 2 is 0, or the main oscillator is stopped, `peri_clk` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock, the block's only clock |
| rst | input | 1 | Synchronous active-high reset, the inverted RESET pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the standby control register, 1 the mode register |
| wr_data | input | 8 | Write data |
| irq_pending | input | 1 | An unmasked interrupt is pending |
| sub_clk_in | input | 1 | Subsystem oscillator level, sampled in `clk` |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Subsystem oscillator feedback enable |
| cpu_clk | output | 1 | Gated CPU clock |
| peri_clk | output | 1 | Peripheral clock, main clock divided by 2 |
| sub_clk_out | output | 1 | Always-on subsystem clock for the timer, watch and clock output |
| cpu_src_sub | output | 1 | 1 while the subsystem clock is the active CPU source |

## Verification
The bench sweeps all eight mode codes and measures each CPU period. A divider tap off by one stage would show up as a period of twice or half the expected value. It tries the forbidden combinations: STOP on the subsystem clock, stopping the main oscillator while it is still the CPU source, stopping the subsystem oscillator while it is selected, and clearing the subsystem select while the main oscillator is stopped. A controller that obeyed any of these writes would freeze the CPU clock or silence `sub_clk_out`, or would switch onto a dead main clock. Wake-up by interrupt and by reset is checked from both HALT and STOP, as is the peripheral clock during each mode. A gate that was not released on wake would leave `cpu_clk` flat.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  // standby control register fields
  localparam int B_SSTOP = 7;   // subsystem oscillator shutdown
  localparam int B_MSTOP = 6;   // main oscillator stop
  localparam int B_SEL   = 5;   // subsystem clock as CPU source
  localparam int B_PERI  = 2;   // peripheral clock enable
  localparam logic [7:0] STBY_RESET = 8'h04;
  localparam logic [7:0] MODE_RESET = 8'h00;

  localparam logic ADDR_STBY = 1'b0;
  localparam logic ADDR_MODE = 1'b1;

  typedef enum logic [1:0] {
    REQ_NONE = 2'b00,
    REQ_HALT = 2'b01,
    REQ_STOP = 2'b10,
    REQ_RSVD = 2'b11
  } stby_req_e;
endpackage

// File: rtl/clkgen_div.sv
module clkgen_div #(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  output logic [STAGES-1:0] taps
);
  logic [STAGES-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // tap k has a period of 2^(k+1) main cycles
  for (genvar k = 0; k < STAGES; k++) begin : g_tap
    assign taps[k] = cnt_q[k];
  end
endmodule

// File: rtl/clkgen_switch.sv
module clkgen_switch #(
  parameter int NCAND     = 6,
  parameter int IDX_W     = 3,
  parameter int SUB_IDX   = 5,
  parameter int RESET_IDX = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCAND-1:0] cand,
  input  logic [IDX_W-1:0] tgt_idx,
  input  logic             run,
  input  logic             stdby,
  output logic             cpu_clk,
  output logic             src_sub
);
  logic [IDX_W-1:0] cur_q;
  logic             gate_q;
  logic             cpu_q;
  logic             cur_lvl, tgt_lvl;

  always_comb begin
    cur_lvl = cand[cur_q];
    tgt_lvl = cand[tgt_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= IDX_W'(RESET_IDX);
      gate_q <= 1'b1;
      cpu_q  <= 1'b0;
    end else begin
      if (cur_q != tgt_idx && !cur_lvl && !tgt_lvl) cur_q <= tgt_idx;
      if (!cur_lvl) gate_q <= run;
      cpu_q <= cur_lvl & gate_q;
    end
  end

  assign cpu_clk = cpu_q;
  assign src_sub = (cur_q == IDX_W'(SUB_IDX));

  // R4
  glitch_free_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_q != $past(cur_q)) |-> !cpu_q);

  // R5
  halt_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (stdby && $past(stdby) && !cpu_q) |=> !cpu_q);
endmodule

// File: rtl/clkgen_stby_ctrl.sv
module clkgen_stby_ctrl
  import clkgen_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CODE_W     = 3,
  parameter int DIV_STAGES = 5,
  parameter int IDX_W      = 3,
  parameter int SUB_IDX    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_pending,
  input  logic              src_sub,
  output logic [IDX_W-1:0]  tgt_idx,
  output logic              run,
  output logic              stdby,
  output logic              main_osc_en,
  output logic              sub_osc_en,
  output logic              peri_en
);
  logic              sel_q, main_stop_q, sub_stop_q, peri_q;
  logic              halt_q, stop_q, main_en_q, sub_en_q;
  logic [CODE_W-1:0] code_q;

  logic              sel_nxt, main_stop_nxt, sub_stop_nxt, peri_nxt;
  logic              halt_nxt, stop_nxt, selected;
  logic              wr_sb, wr_md, halt_req, stop_req;
  logic [CODE_W-1:0] code_nxt;
  stby_req_e         req;

  logic unused_bits;
  assign unused_bits = ^{wr_data[4:3], wr_data[DATA_W-1:CODE_W]};

  function automatic logic [IDX_W-1:0] tap_of(input logic [CODE_W-1:0] c);
    if (int'(c) < DIV_STAGES) return IDX_W'(DIV_STAGES - 1 - int'(c));
    return '0;
  endfunction

  always_comb begin
    wr_sb         = wr_en && (wr_addr == ADDR_STBY);
    wr_md         = wr_en && (wr_addr == ADDR_MODE);
    req           = stby_req_e'(wr_data[1:0]);
    sel_nxt       = sel_q;
    main_stop_nxt = main_stop_q;
    sub_stop_nxt  = sub_stop_q;
    peri_nxt      = peri_q;
    if (wr_sb) begin
      // a kept main stop pins the selection to the subsystem clock
      sel_nxt       = wr_data[B_SEL] | (wr_data[B_MSTOP] & main_stop_q);
      main_stop_nxt = wr_data[B_MSTOP] & src_sub & sel_q & sel_nxt;
      sub_stop_nxt  = wr_data[B_SSTOP] & ~sel_nxt & ~sel_q & ~src_sub;
      peri_nxt      = wr_data[B_PERI];
    end
    selected = sel_nxt | src_sub;
    halt_req = wr_sb && (req == REQ_HALT);
    stop_req = wr_sb && (req == REQ_STOP) && !selected;
    halt_nxt = (halt_q | halt_req) & ~irq_pending;
    stop_nxt = (stop_q | stop_req) & ~irq_pending & ~selected;
    code_nxt = wr_md ? wr_data[CODE_W-1:0] : code_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q       <= STBY_RESET[B_SEL];
      main_stop_q <= STBY_RESET[B_MSTOP];
      sub_stop_q  <= STBY_RESET[B_SSTOP];
      peri_q      <= STBY_RESET[B_PERI];
      code_q      <= MODE_RESET[CODE_W-1:0];
      halt_q      <= 1'b0;
      stop_q      <= 1'b0;
      main_en_q   <= 1'b0;
      sub_en_q    <= 1'b1;
    end else begin
      sel_q       <= sel_nxt;
      main_stop_q <= main_stop_nxt;
      sub_stop_q  <= sub_stop_nxt;
      peri_q      <= peri_nxt;
      code_q      <= code_nxt;
      halt_q      <= halt_nxt;
      stop_q      <= stop_nxt;
      main_en_q   <= ~stop_nxt & ~main_stop_nxt;
      sub_en_q    <= ~sub_stop_nxt;
    end
  end

  assign tgt_idx     = (sel_q | main_stop_q) ? IDX_W'(SUB_IDX) : tap_of(code_q);
  assign stdby       = halt_q | stop_q;
  assign run         = ~stdby;
  assign main_osc_en = main_en_q;
  assign sub_osc_en  = sub_en_q;
  assign peri_en     = peri_q;

  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  always_ff @(posedge clk) begin
    if (rst_seen) begin
      // R2
      rst_osc_chk: assert (!main_en_q);
    end
  end

  // R8
  stop_on_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_sb && req == REQ_STOP && src_sub) |=> !stop_q);

  // R9
  main_stop_src_chk: assert property (@(posedge clk) disable iff (rst)
    main_stop_q |-> src_sub);

  // R10
  sub_stop_src_chk: assert property (@(posedge clk) disable iff (rst)
    sub_stop_q |-> !src_sub);
endmodule

// File: rtl/clkgen_top.sv
module clkgen_top #(
  parameter int DATA_W     = 8,
  parameter int CODE_W     = 3,
  parameter int DIV_STAGES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_pending,
  input  logic              sub_clk_in,
  output logic              main_osc_en,
  output logic              sub_osc_en,
  output logic              cpu_clk,
  output logic              peri_clk,
  output logic              sub_clk_out,
  output logic              cpu_src_sub
);
  localparam int NCAND   = DIV_STAGES + 1;
  localparam int SUB_IDX = DIV_STAGES;
  localparam int IDX_W   = $clog2(NCAND);

  logic [DIV_STAGES-1:0] taps;
  logic [IDX_W-1:0]      tgt_idx;
  logic                  run, stdby, peri_en, sub_q, peri_q;

  clkgen_stby_ctrl #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .DIV_STAGES(DIV_STAGES),
    .IDX_W(IDX_W), .SUB_IDX(SUB_IDX)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_pending(irq_pending), .src_sub(cpu_src_sub),
    .tgt_idx(tgt_idx), .run(run), .stdby(stdby),
    .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en), .peri_en(peri_en)
  );

  clkgen_div #(.STAGES(DIV_STAGES)) u_div (
    .clk(clk), .rst(rst), .run(main_osc_en), .taps(taps)
  );

  clkgen_switch #(
    .NCAND(NCAND), .IDX_W(IDX_W), .SUB_IDX(SUB_IDX), .RESET_IDX(DIV_STAGES - 1)
  ) u_sw (
    .clk(clk), .rst(rst), .cand({sub_q, taps}), .tgt_idx(tgt_idx),
    .run(run), .stdby(stdby), .cpu_clk(cpu_clk), .src_sub(cpu_src_sub)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q  <= 1'b0;
      peri_q <= 1'b0;
    end else begin
      sub_q  <= sub_clk_in & sub_osc_en;
      peri_q <= taps[0] & peri_en & main_osc_en;
    end
  end

  assign sub_clk_out = sub_q;
  assign peri_clk    = peri_q;

  // R12
  peri_stop_chk: assert property (@(posedge clk) disable iff (rst)
    !main_osc_en |=> !peri_q);
endmodule

// File: tb/test_clkgen_top.sv
module test_clkgen_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       irq_pending = 1'b0;
  logic       sub_clk_in = 1'b0;
  logic       main_osc_en, sub_osc_en, cpu_clk, peri_clk, sub_clk_out, cpu_src_sub;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  localparam int SUB_HALF = 7;
  localparam int SUB_PER  = 2 * SUB_HALF;

  clkgen_top i_clkgen_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_pending(irq_pending), .sub_clk_in(sub_clk_in),
    .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en), .cpu_clk(cpu_clk),
    .peri_clk(peri_clk), .sub_clk_out(sub_clk_out), .cpu_src_sub(cpu_src_sub)
  );

  always #2 clk = ~clk;

  initial forever begin
    repeat (SUB_HALF) @(negedge clk);
    sub_clk_in = ~sub_clk_in;
  end

  initial forever begin
    @(posedge clk);
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lvl(input int s);
    case (s)
      0:       return int'(cpu_clk);
      1:       return int'(peri_clk);
      default: return int'(sub_clk_out);
    endcase
  endfunction

  task automatic period(input int s, output int p);
    int t = 0;
    while (lvl(s) != 0 && t < 400) begin @(negedge clk); t++; end
    while (lvl(s) != 1 && t < 400) begin @(negedge clk); t++; end
    p = 0;
    while (lvl(s) == 1 && t < 800) begin @(negedge clk); p++; t++; end
    while (lvl(s) == 0 && t < 800) begin @(negedge clk); p++; t++; end
    if (t >= 800 || (t >= 400 && p == 0)) p = -1;
  endtask

  task automatic highs(input int s, input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      if (lvl(s) != 0) h++;
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_irq;
    @(negedge clk); irq_pending = 1'b1;
    @(negedge clk); irq_pending = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_per(input int c);
    if (c < 5) return 1 << (5 - c);
    return 2;
  endfunction

  initial begin
    int p, h;
    // R2: oscillator enable held low during reset
    settle(6);
    chk("R2 main_osc_en in reset", int'(main_osc_en), 0);
    rst = 1'b0;
    settle(5);
    chk("R2 main_osc_en after reset", int'(main_osc_en), 1);
    chk("R1 cpu_src_sub after reset", int'(cpu_src_sub), 0);
    period(0, p); chk("R1 reset cpu period", p, 32);
    period(1, p); chk("R1 reset peri period", p, 2);
    period(2, p); chk("R11 sub_clk_out period", p, SUB_PER);

    // R3: sweep all rate codes
    for (int c = 0; c < 8; c++) begin
      wr(1'b1, 8'(c));
      settle(100);
      period(0, p);
      chk($sformatf("R3 cpu period code %0d", c), p, exp_per(c));
    end
    wr(1'b1, 8'd2);
    settle(100);

    // R5: HALT on main clock
    wr(1'b0, 8'h05);
    settle(20);
    highs(0, 40, h); chk("R5 cpu low in HALT", h, 0);
    chk("R5 main_osc_en in HALT", int'(main_osc_en), 1);
    period(1, p); chk("R5 peri period in HALT", p, 2);
    pulse_irq();
    settle(20);
    period(0, p); chk("R7 cpu period after HALT wake", p, 8);

    // R6: STOP on main clock
    wr(1'b0, 8'h06);
    settle(5);
    chk("R6 main_osc_en in STOP", int'(main_osc_en), 0);
    highs(1, 40, h); chk("R6 peri low in STOP", h, 0);
    highs(0, 40, h); chk("R6 cpu low in STOP", h, 0);
    period(2, p); chk("R11 sub_clk_out in STOP", p, SUB_PER);
    pulse_irq();
    settle(40);
    chk("R7 main_osc_en after STOP wake", int'(main_osc_en), 1);
    period(0, p); chk("R7 cpu period after STOP wake", p, 8);

    // R7: reset ends STOP and restores defaults
    wr(1'b0, 8'h06);
    settle(10);
    @(negedge clk); rst = 1'b1;
    settle(5);
    rst = 1'b0;
    settle(10);
    chk("R7 main_osc_en after reset wake", int'(main_osc_en), 1);
    period(0, p); chk("R7 cpu period after reset wake", p, 32);

    // R9: main stop ignored while main clock active
    wr(1'b0, 8'h44);
    settle(10);
    chk("R9 main stop ignored on main", int'(main_osc_en), 1);
    period(0, p); chk("R9 cpu runs on main", p, 32);

    // R10: subsystem shutdown with main clock
    wr(1'b0, 8'h84);
    settle(20);
    chk("R10 sub_osc_en off", int'(sub_osc_en), 0);
    highs(2, 40, h); chk("R10 sub_clk_out silent", h, 0);
    wr(1'b0, 8'h04);
    settle(20);
    period(2, p); chk("R11 sub_clk_out restored", p, SUB_PER);

    // R4: switch to subsystem clock
    wr(1'b0, 8'h24);
    settle(100);
    chk("R4 cpu_src_sub set", int'(cpu_src_sub), 1);
    period(0, p); chk("R4 cpu period on sub", p, SUB_PER);

    // R10: shutdown ignored while sub selected
    wr(1'b0, 8'hA4);
    settle(20);
    chk("R10 sub_osc_en kept", int'(sub_osc_en), 1);
    period(2, p); chk("R10 sub_clk_out kept", p, SUB_PER);
    period(0, p); chk("R10 cpu kept on sub", p, SUB_PER);

    // R8: STOP ignored on sub
    wr(1'b0, 8'h26);
    settle(10);
    chk("R8 main_osc_en stays", int'(main_osc_en), 1);
    period(0, p); chk("R8 cpu keeps running", p, SUB_PER);

    // R9: main stop accepted on sub
    wr(1'b0, 8'h64);
    settle(10);
    chk("R9 main_osc_en off", int'(main_osc_en), 0);
    highs(1, 40, h); chk("R9 peri low with main stopped", h, 0);
    period(0, p); chk("R9 cpu on sub with main stopped", p, SUB_PER);
    period(2, p); chk("R11 sub_clk_out with main stopped", p, SUB_PER);
    wr(1'b0, 8'h44);
    settle(100);
    chk("R9 stays on sub while main stopped", int'(cpu_src_sub), 1);
    chk("R9 main still stopped", int'(main_osc_en), 0);

    // R5: HALT on sub with main stopped
    wr(1'b0, 8'h65);
    settle(40);
    highs(0, 60, h); chk("R5 cpu low in HALT on sub", h, 0);
    period(2, p); chk("R11 sub_clk_out in HALT", p, SUB_PER);
    pulse_irq();
    settle(40);
    period(0, p); chk("R7 cpu resumes on sub", p, SUB_PER);

    // R12: peripheral clock disabled, main restarted
    wr(1'b0, 8'h20);
    settle(20);
    chk("R12 main_osc_en restarted", int'(main_osc_en), 1);
    highs(1, 40, h); chk("R12 peri off when bit2 clear", h, 0);

    // R4: back to main clock
    wr(1'b0, 8'h04);
    settle(100);
    chk("R4 cpu_src_sub cleared", int'(cpu_src_sub), 0);
    period(0, p); chk("R4 cpu period back on main", p, 32);
    period(1, p); chk("R12 peri period re-enabled", p, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule